// File: doc/BRIEF.md
# Two-Region Flash Erase Range Walker

This block accepts an erase request for a byte range and splits it into single block erases on a flash array that has two erase regions. The low region holds small parameter blocks. The high region holds large main blocks. When a start strobe arrives, the block checks the request in the same cycle. A request that runs past the end of the device is refused. So is a request whose start or end does not fall on a block boundary of the region holding that point.

An accepted request is walked one block at a time. For each block, the walker presents an address to a separate erase engine and waits for that engine to report success or failure. The step is the block size of the region the current address lies in, so it grows from the small size to the large one when the walk crosses into the high region. The block ends every request with exactly one single-cycle outcome pulse: done, invalid, or failed.

Top module: `erase_range_walker`

## Requirements
- R1: With default parameters, the low region runs from 0x000000 to 0x01FFFF as 8 blocks of 0x4000 bytes. The high region runs from 0x020000 to 0x3FFFFF as 31 blocks of 0x20000 bytes, so the device holds 0x400000 bytes. Every issued block address lies below 0x400000.
- R2: A request with nonzero length where start plus length is greater than 0x400000 gives `rsp_invalid` and issues no erase. A range ending exactly at 0x400000 is accepted.
- R3: A start address that is not a multiple of the block size of the region containing it gives `rsp_invalid` and issues no erase.
- R4: An end address (start plus length) that is not a multiple of the block size of its region gives `rsp_invalid` and issues no erase. The region of an address is the last region whose base is less than or equal to that address, so an end of exactly 0x020000 counts as the high region.
- R5: A request of length zero gives `rsp_done` in the cycle after the strobe and issues no erase, whatever its address.
- R6: During a walk, `er_valid` stays high and `er_addr` stays unchanged until the engine answers with `er_done` or `er_fail`. The first block address is the start address.
- R7: After a successful block, the next address is the current address plus the block size of the region holding the current address. The step is 0x4000 below 0x020000 and 0x20000 from there on.
- R8: An `er_fail` answer stops the walk. In the next cycle `rsp_failed` pulses, and no further block is issued.
- R9: `rsp_done` pulses in the cycle after the successful answer for the last block, meaning the block that ends at the end address.
- R10: `busy` is high from the cycle after an accepted strobe until the outcome pulse; in the cycle of the pulse, `busy` is low. A strobe seen while busy is ignored and does not change the walk.
- R11: The three outcome outputs are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Strobe that presents a new request |
| req_addr | input | ADDR_W | Byte address where the range starts |
| req_len | input | ADDR_W | Length of the range in bytes |
| busy | output | 1 | A walk is in progress |
| er_valid | output | 1 | A block erase is requested from the engine |
| er_addr | output | ADDR_W | Base address of the block to erase |
| er_done | input | 1 | The engine finished the current block successfully |
| er_fail | input | 1 | The engine reports that the current block failed |
| rsp_done | output | 1 | Pulse: the request completed |
| rsp_invalid | output | 1 | Pulse: the request was refused |
| rsp_failed | output | 1 | Pulse: a block erase failed and the walk stopped |

## Verification
Requests are applied that lie wholly in the low region, that start low and end high, that start and end in the high region, and that cover the whole device. Together these show whether the step changes at the right address and whether the walk stops at the right block. Refused requests are chosen close to each rule's edge: a start that is aligned for the low region but not the high one, an end landing just past the region boundary, and a range one block past the device size next to one that ends exactly at it. Engine replies come with zero and with several cycles of delay, and a failure is injected on the first block and in the middle of a walk. A second strobe during a walk shows that the walk's state is held.

// File: rtl/erw_pkg.sv
package erw_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } erw_state_e;
endpackage

// File: rtl/erw_region_lookup.sv
module erw_region_lookup #(
   parameter int W1          = 33,
   parameter int P_BLK_BYTES = 16384,
   parameter int P_BLK_CNT   = 8,
   parameter int M_BLK_BYTES = 131072
) (
   input  logic [W1-1:0] addr,
   output logic [W1-1:0] blk_size
);
   localparam longint   P_END_L = longint'(P_BLK_BYTES) * P_BLK_CNT;
   localparam logic [W1-1:0] P_END = W1'(P_END_L);

   initial begin
      a_pow2_small : assert ((P_BLK_BYTES & (P_BLK_BYTES - 1)) == 0)
         else $error("small block size must be a power of two");
      a_pow2_large : assert ((M_BLK_BYTES & (M_BLK_BYTES - 1)) == 0)
         else $error("large block size must be a power of two");
      a_order      : assert (M_BLK_BYTES >= P_BLK_BYTES)
         else $error("large blocks must not be smaller than small blocks");
   end

   // last region whose base does not exceed the address
   always_comb begin
      if (addr < P_END) blk_size = W1'(P_BLK_BYTES);
      else              blk_size = W1'(M_BLK_BYTES);
   end
endmodule

// File: rtl/erw_req_check.sv
module erw_req_check #(
   parameter int ADDR_W      = 32,
   parameter int P_BLK_BYTES = 16384,
   parameter int P_BLK_CNT   = 8,
   parameter int M_BLK_BYTES = 131072,
   parameter int M_BLK_CNT   = 31
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] len,
   output logic              empty,
   output logic              reject,
   output logic [ADDR_W:0]   end_addr
);
   localparam int     W1      = ADDR_W + 1;
   localparam longint TOTAL_L = longint'(P_BLK_BYTES) * P_BLK_CNT
                              + longint'(M_BLK_BYTES) * M_BLK_CNT;
   localparam logic [W1-1:0] TOTAL = W1'(TOTAL_L);

   initial begin
      a_fits : assert (TOTAL_L <= (longint'(1) << ADDR_W))
         else $error("device does not fit in the address width");
   end

   logic [W1-1:0] point [2];
   logic [W1-1:0] size  [2];
   logic [1:0]    misaligned;

   assign end_addr = {1'b0, addr} + {1'b0, len};
   assign point[0] = {1'b0, addr};
   assign point[1] = end_addr;

   for (genvar gi = 0; gi < 2; gi++) begin : g_probe
      erw_region_lookup #(
         .W1(W1), .P_BLK_BYTES(P_BLK_BYTES),
         .P_BLK_CNT(P_BLK_CNT), .M_BLK_BYTES(M_BLK_BYTES)
      ) u_lookup (
         .addr    (point[gi]),
         .blk_size(size[gi])
      );
      assign misaligned[gi] = (point[gi] & (size[gi] - W1'(1))) != '0;
   end

   assign empty  = (len == '0);
   assign reject = !empty && ((end_addr > TOTAL) || (misaligned != 2'b00));
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
   import erw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int P_BLK_BYTES = 16384,
   parameter int P_BLK_CNT   = 8,
   parameter int M_BLK_BYTES = 131072,
   parameter int M_BLK_CNT   = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] req_len,
   output logic              busy,
   output logic              er_valid,
   output logic [ADDR_W-1:0] er_addr,
   input  logic              er_done,
   input  logic              er_fail,
   output logic              rsp_done,
   output logic              rsp_invalid,
   output logic              rsp_failed
);
   localparam int     W1      = ADDR_W + 1;
   localparam longint TOTAL_L = longint'(P_BLK_BYTES) * P_BLK_CNT
                              + longint'(M_BLK_BYTES) * M_BLK_CNT;
   localparam logic [W1-1:0] TOTAL = W1'(TOTAL_L);

   erw_state_e    state;
   logic [W1-1:0] cur;
   logic [W1-1:0] end_q;
   logic [W1-1:0] step;
   logic [W1-1:0] nxt;
   logic          chk_empty;
   logic          chk_reject;
   logic [W1-1:0] chk_end;

   erw_req_check #(
      .ADDR_W(ADDR_W), .P_BLK_BYTES(P_BLK_BYTES), .P_BLK_CNT(P_BLK_CNT),
      .M_BLK_BYTES(M_BLK_BYTES), .M_BLK_CNT(M_BLK_CNT)
   ) u_check (
      .addr    (req_addr),
      .len     (req_len),
      .empty   (chk_empty),
      .reject  (chk_reject),
      .end_addr(chk_end)
   );

   erw_region_lookup #(
      .W1(W1), .P_BLK_BYTES(P_BLK_BYTES),
      .P_BLK_CNT(P_BLK_CNT), .M_BLK_BYTES(M_BLK_BYTES)
   ) u_step (
      .addr    (cur),
      .blk_size(step)
   );

   assign nxt      = cur + step;
   assign busy     = (state == ST_WALK);
   assign er_valid = (state == ST_WALK);
   assign er_addr  = cur[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cur         <= '0;
         end_q       <= '0;
         rsp_done    <= 1'b0;
         rsp_invalid <= 1'b0;
         rsp_failed  <= 1'b0;
      end else begin
         rsp_done    <= 1'b0;
         rsp_invalid <= 1'b0;
         rsp_failed  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_start) begin
                  if (chk_empty)       rsp_done    <= 1'b1;
                  else if (chk_reject) rsp_invalid <= 1'b1;
                  else begin
                     state <= ST_WALK;
                     cur   <= {1'b0, req_addr};
                     end_q <= chk_end;
                  end
               end
            end
            ST_WALK: begin
               if (er_fail) begin
                  rsp_failed <= 1'b1;
                  state      <= ST_IDLE;
               end else if (er_done) begin
                  if (nxt == end_q) begin
                     rsp_done <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     cur <= nxt;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R11: outcome pulses never overlap
   p_one_outcome_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_done, rsp_invalid, rsp_failed}));

   // R6: request held until the engine answers
   p_hold_request_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      er_valid && !er_done && !er_fail |=> er_valid && $stable(er_addr));

   // R8: failure ends the walk at once
   p_fail_stops_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      er_valid && er_fail |=> rsp_failed && !er_valid);

   // R7: after a successful block the address only moves upward
   p_advance_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      er_valid && er_done && !er_fail |=> rsp_done || (er_addr > $past(er_addr)));

   // R1: no address beyond the device
   p_in_device_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      er_valid |-> ({1'b0, er_addr} < TOTAL));

   // R10: an idle strobe yields either a walk or an immediate outcome
   p_strobe_outcome_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy && req_start |=> busy ^ (rsp_done || rsp_invalid));
endmodule

// File: tb/erase_range_walker_tb.sv
module erase_range_walker_tb;
   localparam int     AW    = 32;
   localparam longint TOTAL = 64'h40_0000;
   localparam longint BOUND = 64'h2_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_start = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [AW-1:0] req_len = '0;
   logic          busy, er_valid, rsp_done, rsp_invalid, rsp_failed;
   logic [AW-1:0] er_addr;
   logic          er_done = 1'b0;
   logic          er_fail = 1'b0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   erase_range_walker u_dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
      .req_len(req_len), .busy(busy), .er_valid(er_valid), .er_addr(er_addr),
      .er_done(er_done), .er_fail(er_fail), .rsp_done(rsp_done),
      .rsp_invalid(rsp_invalid), .rsp_failed(rsp_failed)
   );

   function automatic longint blk_of(longint a);
      return (a < BOUND) ? 64'h4000 : 64'h2_0000;
   endfunction

   // compare all outputs with the model's expectation for this cycle
   task automatic expect_cycle(bit b, bit v, longint a, bit d, bit i, bit f, string tag);
      logic [4:0] act, exp;
      act = {busy, er_valid, rsp_done, rsp_invalid, rsp_failed};
      exp = {b, v, d, i, f};
      checks++;
      if (act !== exp || (v && er_addr !== a[AW-1:0])) begin
         errors++;
         $display("FAIL %s: busy/valid/done/inv/fail=%b addr=%h expected %b addr=%h",
                  tag, act, er_addr, exp, a[AW-1:0]);
      end
   endtask

   // fail_idx < 0 means no failure; poke sends a strobe mid-walk
   task automatic run(longint a0, longint len, int fail_idx, int lat, bit poke, string tag);
      longint e, a;
      bit bad;
      int k;
      bit failed_now;
      e = a0 + len;
      bad = (e > TOTAL) || (a0 % blk_of(a0) != 0) || (e % blk_of(e) != 0);
      @(negedge clk);
      req_start = 1'b1; req_addr = a0[AW-1:0]; req_len = len[AW-1:0];
      @(negedge clk);
      req_start = 1'b0;
      if (len == 0) begin
         expect_cycle(0, 0, 0, 1, 0, 0, {tag, " R5 empty"});
      end else if (bad) begin
         expect_cycle(0, 0, 0, 0, 1, 0, {tag, " R2/R3/R4 refuse"});
      end else begin
         a = a0; k = 0; failed_now = 0;
         while (a < e && !failed_now) begin
            for (int w = 0; w < lat; w++) begin
               expect_cycle(1, 1, a, 0, 0, 0, {tag, " R6 hold"});
               if (poke && k == 0 && w == 0) begin
                  req_start = 1'b1; req_addr = '0; req_len = '0;
               end
               @(negedge clk);
               req_start = 1'b0;
               if (poke && k == 0 && w == 0)
                  expect_cycle(1, 1, a, 0, 0, 0, {tag, " R10 strobe ignored"});
            end
            expect_cycle(1, 1, a, 0, 0, 0, {tag, " R7 address"});
            if (k == fail_idx) begin er_fail = 1'b1; failed_now = 1; end
            else er_done = 1'b1;
            @(negedge clk);
            er_done = 1'b0; er_fail = 1'b0;
            a = a + blk_of(a);
            k++;
         end
         if (failed_now) expect_cycle(0, 0, 0, 0, 0, 1, {tag, " R8 failed"});
         else            expect_cycle(0, 0, 0, 1, 0, 0, {tag, " R9 done"});
      end
      @(negedge clk);
      expect_cycle(0, 0, 0, 0, 0, 0, {tag, " R11 single pulse"});
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_cycle(0, 0, 0, 0, 0, 0, "R10 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      expect_cycle(0, 0, 0, 0, 0, 0, "R10 idle after reset");
      run(64'h123,    0,          -1, 0, 0, "R5 zero length odd address");
      run(64'h3E0000, 64'h40000,  -1, 0, 0, "R2 past end");
      run(64'h3E0000, 64'h20000,  -1, 1, 0, "R2 exact end");
      run(64'h2000,   64'h4000,   -1, 0, 0, "R3 unaligned small");
      run(64'h24000,  64'h20000,  -1, 0, 0, "R3 unaligned large");
      run(64'h0,      64'h24000,  -1, 0, 0, "R4 end past boundary");
      run(64'h4000,   64'h8000,   -1, 2, 0, "R7 small region walk");
      run(64'h18000,  64'h48000,  -1, 3, 1, "R7 crossing walk");
      run(64'h18000,  64'h48000,   2, 1, 0, "R8 mid failure");
      run(64'h20000,  64'h40000,   0, 0, 0, "R8 first failure");
      run(64'h0,      TOTAL,      -1, 0, 0, "R1 whole device");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule